// File: doc/BRIEF.md
# Pseudo-SRAM Access Controller

This block connects a clocked system to a 16-bit asynchronous pseudo-static RAM. The user side is a valid/ready request port. Each request carries a word address, 16 bits of write data, a write flag and two active-high byte-lane enables. Every request is answered by a single-cycle `rsp_valid` pulse, and a read returns its data on `rsp_rdata` at the same time. The controller holds one request at a time. `req_ready` is low while an access is in progress, while sleep is requested or active, and while the wake-up wait runs. A requester raises `req_valid`, keeps its fields stable until a cycle in which `req_ready` is also high, and the request is taken at the end of that cycle. The response port has no back-pressure.

On the memory side the controller drives active-low chip select, write strobe, read enable, upper-lane and lower-lane selects, and the sleep control. The shared data bus is split into an output word, an input word and a drive enable, which the chip's pad ring combines. Read and write pulse widths come from the memory access time, in ns, and the clock period, in ps. The count is rounded up to whole cycles: 4 cycles for 70 ns at 20 ns.

Holding `sleep_req` high puts the memory into its low-power state once the controller is idle. That state does not keep data, so entering it sets a sticky `contents_lost` flag. The flag is cleared only by reset. When `sleep_req` is released, the controller waits a programmed number of cycles before it accepts requests again.

Top module: `psram_ctrl`

## Requirements
- R1: Out of reset, and whenever `req_ready` is high, the controller drives `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n`, `mem_lb_n` and `mem_zz_n` high and `mem_dq_oe` low. `contents_lost` resets to 0.
- R2: A write drives `mem_ce_n` and `mem_we_n` low and drives `mem_dq_o` with the write data (`mem_dq_oe` high). It drives `mem_lb_n` low when `req_be[0]` is set and `mem_ub_n` low when `req_be[1]` is set. `mem_we_n` stays low for exactly the access cycle count (4 at defaults).
- R3: After `mem_we_n` rises, address, data drive and chip select are held for one more cycle. `rsp_valid` is seen in the 6th cycle after the accepting edge (defaults).
- R4: A read drives `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high and the bus released, for the access cycle count. The bus is then sampled. A lane whose `req_be` bit is clear returns 0 on `rsp_rdata`. `rsp_valid` is seen in the 5th cycle after acceptance (defaults).
- R5: A single-lane write changes only that byte (bits 7..0 for `req_be[0]`, 15..8 for `req_be[1]`). The other byte of the word keeps its previous value.
- R6: A request with `req_be` = 0 completes with `rsp_valid` in the first cycle after acceptance and `rsp_rdata` = 0. `mem_ce_n` stays high throughout.
- R7: `mem_we_n` and `mem_oe_n` are never low together. `mem_dq_oe` never rises in a cycle in which, or right after one in which, `mem_oe_n` is low.
- R8: While `sleep_req` is high, `req_ready` is low. Once idle, `mem_zz_n` goes low with `mem_ce_n` high, and `contents_lost` becomes 1 and stays 1 until reset.
- R9: After `sleep_req` falls, `mem_zz_n` goes high in the next cycle. `req_ready` returns in the cycle `WAKE_CYCLES`+1 after the release.
- R10: A request presented while `req_ready` is low is stalled, and no memory pin moves for it. It is accepted once `req_ready` rises and is then served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| sleep_req | input | 1 | Level request for memory low-power state |
| contents_lost | output | 1 | Sticky: memory was put to sleep since reset |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read enable, active low |
| mem_ub_n | output | 1 | Upper-byte select, active low |
| mem_lb_n | output | 1 | Lower-byte select, active low |
| mem_zz_n | output | 1 | Sleep control, active low |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from memory |

## Verification
Properties checked on every cycle:
- the write strobe and read enable never overlap;
- the bus driver never turns on against or right after a read;
- the write hold cycle after the strobe rises;
- no chip select without an active lane;
- quiet pins and a closed port during sleep;
- the stickiness of the lost-contents flag.

Only the bench's scenarios can show the following:
- that stored data survives partial-lane writes with the other byte intact;
- that disabled lanes read as zero;
- the exact response latencies and strobe width;
- the wake-up cycle count;
- that a request stalled across sleep is eventually served.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int DW = 16;
  localparam int LANE_W = 8;
  localparam int LANES = DW / LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WR    = 2'd1,
    ST_WHOLD = 2'd2,
    ST_RD    = 2'd3
  } acc_st_t;

  typedef enum logic [1:0] {
    SL_AWAKE = 2'd0,
    SL_SLEEP = 2'd1,
    SL_WAKE  = 2'd2
  } slp_st_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/psram_wait_cnt.sv
module psram_wait_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/psram_sleep_ctl.sv
module psram_sleep_ctl import psram_pkg::*; #(
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic ctrl_idle,
  output logic zz_n,
  output logic awake,
  output logic lost
);

  localparam int WW = $clog2(WAKE_CYCLES + 1);

  slp_st_t sl;
  logic    wk_load;
  logic    wk_zero;

  assign wk_load = (sl == SL_SLEEP) && !sleep_req;

  psram_wait_cnt #(.W(WW)) u_wake_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wk_load),
    .load_val (WW'(WAKE_CYCLES - 1)),
    .zero     (wk_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl   <= SL_AWAKE;
      lost <= 1'b0;
    end else begin
      unique case (sl)
        SL_AWAKE: if (sleep_req && ctrl_idle) begin
          sl   <= SL_SLEEP;
          lost <= 1'b1;
        end
        SL_SLEEP: if (!sleep_req) sl <= SL_WAKE;
        SL_WAKE:  if (wk_zero) sl <= SL_AWAKE;
        default:  sl <= SL_AWAKE;
      endcase
    end
  end

  assign zz_n  = (sl != SL_SLEEP);
  assign awake = (sl == SL_AWAKE);

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl import psram_pkg::*; #(
  parameter int AW          = 20,
  parameter int CLK_PS      = 20000,
  parameter int ACCESS_NS   = 70,
  parameter int WAKE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              sleep_req,
  output logic              contents_lost,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic              mem_zz_n,
  output logic [DW-1:0]     mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_i
);

  localparam int ACC_CYC = ceil_div(ACCESS_NS * 1000, CLK_PS);
  localparam int CW      = $clog2(ACC_CYC + 1);

  acc_st_t          st;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_q;
  logic             accept;
  logic             tmr_load;
  logic             tmr_zero;
  logic             awake;
  logic             active;
  logic [LANES-1:0] lane_sel_n;
  logic [DW-1:0]    rd_masked;

  assign req_ready = (st == ST_IDLE) && awake && !sleep_req;
  assign accept    = req_valid && req_ready;
  assign tmr_load  = accept && (req_be != '0);

  psram_wait_cnt #(.W(CW)) u_acc_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (CW'(ACC_CYC - 1)),
    .zero     (tmr_zero)
  );

  psram_sleep_ctl #(.WAKE_CYCLES(WAKE_CYCLES)) u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .ctrl_idle (st == ST_IDLE),
    .zz_n      (mem_zz_n),
    .awake     (awake),
    .lost      (contents_lost)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          if (req_be == '0) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            st      <= req_write ? ST_WR : ST_RD;
          end
        end
        ST_WR: if (tmr_zero) st <= ST_WHOLD;
        ST_WHOLD: begin
          st        <= ST_IDLE;
          rsp_valid <= 1'b1;
        end
        ST_RD: if (tmr_zero) begin
          st        <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= rd_masked;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign active = (st != ST_IDLE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_sel_n[g] = ~(active & be_q[g]);
    assign rd_masked[g*LANE_W +: LANE_W] =
      be_q[g] ? mem_dq_i[g*LANE_W +: LANE_W] : '0;
  end

  assign mem_addr  = addr_q;
  assign mem_ce_n  = ~active;
  assign mem_we_n  = (st != ST_WR);
  assign mem_oe_n  = (st != ST_RD);
  assign mem_lb_n  = lane_sel_n[0];
  assign mem_ub_n  = lane_sel_n[LANES-1];
  assign mem_dq_oe = (st == ST_WR) || (st == ST_WHOLD);
  assign mem_dq_o  = wdata_q;

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic          mem_zz_n,
  input logic          mem_dq_oe,
  input logic          contents_lost,
  input logic [AW-1:0] mem_addr
);

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R7
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  // R7
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (mem_oe_n && $past(mem_oe_n)));

  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && !mem_ce_n));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr)));

  // R6
  lane_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !(mem_ub_n && mem_lb_n));

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_zz_n |-> (mem_ce_n && !req_ready));

  // R8
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    contents_lost |=> contents_lost);

endmodule

bind psram_ctrl psram_ctrl_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_ce_n      (mem_ce_n),
  .mem_we_n      (mem_we_n),
  .mem_oe_n      (mem_oe_n),
  .mem_ub_n      (mem_ub_n),
  .mem_lb_n      (mem_lb_n),
  .mem_zz_n      (mem_zz_n),
  .mem_dq_oe     (mem_dq_oe),
  .contents_lost (contents_lost),
  .mem_addr      (mem_addr)
);

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;

  localparam int AW = 20;
  localparam int WAKE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic          sleep_req = 1'b0;
  logic          contents_lost;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_zz_n;
  logic [15:0]   mem_dq_o;
  logic          mem_dq_oe;
  logic [15:0]   mem_dq_i;

  always #10 clk = ~clk;

  psram_ctrl #(.AW(AW), .WAKE_CYCLES(WAKE)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sleep_req(sleep_req), .contents_lost(contents_lost),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_zz_n(mem_zz_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // behavioural memory: 256 words, undriven lanes read as EE
  logic [15:0] mem [256];
  logic        rd_on;
  assign rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = {(rd_on && !mem_ub_n) ? mem[mem_addr[7:0]][15:8] : 8'hEE,
                     (rd_on && !mem_lb_n) ? mem[mem_addr[7:0]][7:0]  : 8'hEE};

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_ub_n) mem[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    end
  end

  // pin monitor, sampled mid-cycle
  int            ce_low_cnt = 0, we_run = 0, last_we_run = 0;
  int            hold_err = 0, conflict = 0;
  logic          prev_we_n = 1'b1, prev_oe_n = 1'b1;
  logic [AW-1:0] prev_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) ce_low_cnt++;
      if (!mem_we_n) we_run++;
      if (mem_we_n && !prev_we_n) begin
        last_we_run = we_run;
        we_run = 0;
        if (!mem_dq_oe || mem_ce_n || mem_addr != prev_addr) hold_err++;
      end
      if (mem_dq_oe && (!mem_oe_n || !prev_oe_n)) conflict++;
    end
    prev_we_n = mem_we_n;
    prev_oe_n = mem_oe_n;
    prev_addr = mem_addr;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input bit w, input logic [7:0] a, input logic [15:0] d,
                         input logic [1:0] be, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a);
    req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  typedef struct packed {
    logic        w;
    logic [7:0]  a;
    logic [15:0] d;
    logic [1:0]  be;
    logic [15:0] exp;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 16'h1234, 2'b11, 16'h0000, 4'd6},  // R2 full write
    '{1'b0, 8'h10, 16'h0000, 2'b11, 16'h1234, 4'd5},  // R4 full read
    '{1'b1, 8'h10, 16'hABCD, 2'b01, 16'h0000, 4'd6},  // R5 low lane
    '{1'b0, 8'h10, 16'h0000, 2'b11, 16'h12CD, 4'd5},  // R5
    '{1'b1, 8'h10, 16'h5678, 2'b10, 16'h0000, 4'd6},  // R5 high lane
    '{1'b0, 8'h10, 16'h0000, 2'b10, 16'h5600, 4'd5},  // R4 low masked
    '{1'b0, 8'h10, 16'h0000, 2'b01, 16'h00CD, 4'd5},  // R4 high masked
    '{1'b1, 8'h20, 16'hFFFF, 2'b00, 16'h0000, 4'd1},  // R6 null write
    '{1'b0, 8'h20, 16'h0000, 2'b11, 16'h0000, 4'd5},  // R6 nothing stored
    '{1'b0, 8'h10, 16'h0000, 2'b00, 16'h0000, 4'd1},  // R6 null read
    '{1'b1, 8'h03, 16'hA5A5, 2'b11, 16'h0000, 4'd6},  // R3 write then read
    '{1'b0, 8'h03, 16'h0000, 2'b11, 16'hA5A5, 4'd5}   // R7 read after write
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    int lat, ce0, w;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_zz_n} == 6'h3F,
          "R1", "pins idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_zz_n}, 6'h3F);
    check(!mem_dq_oe && req_ready && !contents_lost, "R1", "drive/ready/lost",
          {mem_dq_oe, req_ready, contents_lost}, 3'b010);

    for (int i = 0; i < NV; i++) begin
      ce0 = ce_low_cnt;
      run_req(VECS[i].w, VECS[i].a, VECS[i].d, VECS[i].be, rd, lat);
      check(lat == int'(VECS[i].lat), VECS[i].w ? "R3" : "R4", "latency",
            lat, VECS[i].lat);
      if (!VECS[i].w || VECS[i].be == 2'b00)
        check(rd == VECS[i].exp, "R5", "read data", rd, VECS[i].exp);
      if (VECS[i].be == 2'b00)
        check(ce_low_cnt == ce0, "R6", "no chip select", ce_low_cnt - ce0, 0);
      else if (VECS[i].w)
        check(last_we_run == 4, "R2", "strobe width", last_we_run, 4);
    end

    check(hold_err == 0, "R3", "write hold", hold_err, 0);
    check(conflict == 0, "R7", "bus overlap", conflict, 0);

    // R8 sleep entry with request stalled
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    check(!mem_zz_n && !req_ready && contents_lost, "R8", "sleep entered",
          {mem_zz_n, req_ready, contents_lost}, 3'b001);
    ce0 = ce_low_cnt;
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(8'h10); req_be = 2'b11;
    repeat (5) @(negedge clk);
    check(!rsp_valid && ce_low_cnt == ce0, "R10", "stalled in sleep",
          ce_low_cnt - ce0, 0);
    sleep_req = 1'b0;
    w = 0;
    do begin
      @(negedge clk);
      w++;
      if (w == 1) check(mem_zz_n, "R9", "wake pin", mem_zz_n, 1);
    end while (!req_ready && w < 50);
    check(w == WAKE + 1, "R9", "wake delay", w, WAKE + 1);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 5 && rsp_rdata == 16'h56CD, "R10", "served after wake",
          rsp_rdata, 16'h56CD);
    check(contents_lost, "R8", "lost sticky", contents_lost, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule